// File: doc/BRIEF.md
# In-System Configuration Mode Tracker

This block follows the configuration mode of a programmable device while a boundary-scan controller drives it. Decoded one-cycle event pulses arrive from the instruction logic and the TAP controller: the enable instruction was executed, the disable instruction was executed, some other non-test instruction was executed, the TAP sits in Test-Logic-Reset, and the startup sequence has finished. A level input reports whether the configuration status (CRC and error checks) is good. The tracker answers with its current mode, the two mode flags (`flag_enabled`, `flag_done`), one-cycle requests to the startup and shutdown sequencers, and a level that keeps the user I/O disabled.

The four modes are Unprogrammed, Accessed, Complete and Operational. Which way the machine leaves Accessed and Complete depends on whether the done flag is set. Operational does not release the I/O by itself. A startup sequence must be requested and finished while in Operational before the I/O becomes active. All state and flag updates take effect on the clock edge after the input pulse.

Top module: `cfg_isc_mode`

## Requirements
- R1: While `rst_n` is low, and after it rises, `mode` is Unprogrammed (2'b00), both flags are 0, `io_disable` is 1 and both request outputs are 0.
- R2: In Unprogrammed, `ev_enable` moves `mode` to Accessed (2'b01) on the next edge with `flag_enabled` 1 and `flag_done` 0.
- R3: In Operational (2'b11), `ev_enable` moves `mode` to Accessed, sets `flag_enabled`, keeps `flag_done` at 1, disables the I/O and raises `shutdown_req` for exactly the one following cycle.
- R4: In Accessed, `startup_done` moves `mode` to Complete (2'b10), clears `flag_enabled` and loads `flag_done` with `status_ok` sampled in the same cycle.
- R5: Complete lasts one cycle. It then moves to Operational if `flag_done` is 1 and to Unprogrammed if it is 0. All event inputs are ignored while in Complete.
- R6: In Accessed, `tap_reset` moves `mode` straight to Operational (clearing `flag_enabled`) when `flag_done` is 1. It has no effect when `flag_done` is 0.
- R7: Entering Operational leaves `io_disable` at 1. `ev_disable` in Operational raises `startup_req` for one cycle, and a later `startup_done` in Operational then drops `io_disable` to 0.
- R8: In Accessed, `ev_disable` raises `startup_req` for one cycle and leaves `mode` and flags unchanged.
- R9: `ev_other` alone changes neither `mode`, the flags nor `io_disable` in any mode.
- R10: In Accessed, `startup_done` takes priority over `tap_reset` when both are seen in the same cycle.
- R11: `startup_done` in Operational with no startup request pending leaves `io_disable` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| ev_enable | input | 1 | Pulse: enable instruction executed |
| ev_disable | input | 1 | Pulse: disable instruction executed |
| ev_other | input | 1 | Pulse: other non-test instruction executed |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| startup_done | input | 1 | Pulse: startup sequence finished |
| status_ok | input | 1 | Configuration status good |
| mode | output | 2 | 00 Unprogrammed, 01 Accessed, 10 Complete, 11 Operational |
| flag_enabled | output | 1 | Mode flag: access enabled |
| flag_done | output | 1 | Mode flag: configuration done |
| shutdown_req | output | 1 | One-cycle shutdown request |
| startup_req | output | 1 | One-cycle startup request |
| io_disable | output | 1 | User I/O held disabled |

## Verification
The hardest path to reach is the direct jump from Accessed to Operational on Test-Logic-Reset. It needs `flag_done` already set while Accessed, and that only happens if Accessed was entered from Operational. The stimulus therefore first completes a good configuration, steps through Complete into Operational, re-enters Accessed with the enable instruction, and only then asserts `tap_reset`. The bench also drives the same Test-Logic-Reset pulse while `flag_done` is clear, to show that it is ignored there. It also presents `startup_done` and `tap_reset` together to exercise the priority between them.

// File: rtl/cfg_mode_pkg.sv
package cfg_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_UNPROG = 2'b00,
    MODE_ACCESS = 2'b01,
    MODE_SETTLE = 2'b10,
    MODE_OPER   = 2'b11
  } cfg_mode_e;

  // next mode from the current mode and the qualified events
  function automatic cfg_mode_e mode_step(input cfg_mode_e cur,
                                          input logic      enable_ev,
                                          input logic      start_end,
                                          input logic      tlr,
                                          input logic      done);
    cfg_mode_e nxt;
    nxt = cur;
    unique case (cur)
      MODE_UNPROG: if (enable_ev) nxt = MODE_ACCESS;
      MODE_ACCESS: begin
        if (start_end)        nxt = MODE_SETTLE;
        else if (tlr && done) nxt = MODE_OPER;
      end
      MODE_SETTLE: nxt = done ? MODE_OPER : MODE_UNPROG;
      MODE_OPER:   if (enable_ev) nxt = MODE_ACCESS;
      default:     nxt = MODE_UNPROG;
    endcase
    return nxt;
  endfunction

  // done flag update: loaded only at the end of startup in Accessed
  function automatic logic done_step(input cfg_mode_e cur,
                                     input logic      start_end,
                                     input logic      ok,
                                     input logic      done);
    logic d;
    d = done;
    if (cur == MODE_ACCESS && start_end) d = ok;
    if (cur == MODE_UNPROG)              d = 1'b0;
    return d;
  endfunction

endpackage

// File: rtl/cfg_mode_core.sv
module cfg_mode_core
  import cfg_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_enable,
  input  logic      tap_reset,
  input  logic      startup_done,
  input  logic      status_ok,
  output cfg_mode_e mode_q,
  output logic      enabled_q,
  output logic      done_q,
  output logic      leave_oper,
  output logic      access_hold
);

  cfg_mode_e mode_d;
  logic      enabled_d;
  logic      done_d;
  logic      enter_access;

  assign mode_d       = mode_step(mode_q, ev_enable, startup_done, tap_reset, done_q);
  assign done_d       = done_step(mode_q, startup_done, status_ok, done_q);
  assign enter_access = (mode_q != MODE_ACCESS) && (mode_d == MODE_ACCESS);
  assign leave_oper   = (mode_q == MODE_OPER) && (mode_d == MODE_ACCESS);
  assign access_hold  = (mode_q == MODE_ACCESS) && (mode_d == MODE_ACCESS);

  always_comb begin
    enabled_d = enabled_q;
    if (enter_access)             enabled_d = 1'b1;
    else if (mode_d != MODE_ACCESS) enabled_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_UNPROG;
      enabled_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      enabled_q <= enabled_d;
      done_q    <= done_d;
    end
  end

endmodule

// File: rtl/cfg_io_ctrl.sv
module cfg_io_ctrl
  import cfg_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cfg_mode_e mode_q,
  input  logic      ev_enable,
  input  logic      ev_disable,
  input  logic      startup_done,
  input  logic      leave_oper,
  input  logic      access_hold,
  output logic      io_disable,
  output logic      startup_req,
  output logic      shutdown_req
);

  logic in_oper;
  logic io_active_q;
  logic pend_q;
  logic io_on;
  logic oper_start;
  logic access_start;

  assign in_oper      = (mode_q == MODE_OPER) && !ev_enable;
  assign io_on        = in_oper && startup_done && pend_q;
  assign oper_start   = in_oper && ev_disable && !io_on;
  assign access_start = access_hold && ev_disable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_active_q  <= 1'b0;
      pend_q       <= 1'b0;
      startup_req  <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      startup_req  <= oper_start || access_start;
      shutdown_req <= leave_oper;
      if (leave_oper || mode_q != MODE_OPER) begin
        io_active_q <= 1'b0;
        pend_q      <= 1'b0;
      end else if (io_on) begin
        io_active_q <= 1'b1;
        pend_q      <= 1'b0;
      end else if (oper_start) begin
        pend_q      <= 1'b1;
      end
    end
  end

  assign io_disable = !io_active_q;

endmodule

// File: rtl/cfg_isc_mode.sv
module cfg_isc_mode
  import cfg_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_enable,
  input  logic             ev_disable,
  input  logic             ev_other,
  input  logic             tap_reset,
  input  logic             startup_done,
  input  logic             status_ok,
  output logic [MODE_W-1:0] mode,
  output logic             flag_enabled,
  output logic             flag_done,
  output logic             shutdown_req,
  output logic             startup_req,
  output logic             io_disable
);

  cfg_mode_e mode_q;
  logic      leave_oper;
  logic      access_hold;
  logic      other_seen;

  // other non-test instructions carry no transition in any mode (R9)
  assign other_seen = ev_other;

  cfg_mode_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_enable    (ev_enable),
    .tap_reset    (tap_reset),
    .startup_done (startup_done),
    .status_ok    (status_ok),
    .mode_q       (mode_q),
    .enabled_q    (flag_enabled),
    .done_q       (flag_done),
    .leave_oper   (leave_oper),
    .access_hold  (access_hold)
  );

  cfg_io_ctrl u_io (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .ev_enable    (ev_enable),
    .ev_disable   (ev_disable),
    .startup_done (startup_done),
    .leave_oper   (leave_oper),
    .access_hold  (access_hold),
    .io_disable   (io_disable),
    .startup_req  (startup_req),
    .shutdown_req (shutdown_req)
  );

  assign mode = mode_q;

  logic unused_ok;
  assign unused_ok = other_seen;

endmodule

// File: rtl/cfg_isc_mode_chk.sv
module cfg_isc_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_enable,
  input logic       ev_disable,
  input logic       ev_other,
  input logic       tap_reset,
  input logic       startup_done,
  input logic       status_ok,
  input logic [1:0] mode,
  input logic       flag_enabled,
  input logic       flag_done,
  input logic       shutdown_req,
  input logic       startup_req,
  input logic       io_disable
);

  a_r1_unprog_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!flag_done && !flag_enabled && io_disable));

  a_r2_enter_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && ev_enable) |=> (mode == 2'b01 && flag_enabled));

  a_r3_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && ev_enable) |=> (mode == 2'b01 && shutdown_req && io_disable && flag_done));

  a_r3_shutdown_single: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  a_r4_startup_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && startup_done) |=> (mode == 2'b10 && !flag_enabled && flag_done == $past(status_ok)));

  a_r5_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (mode == ($past(flag_done) ? 2'b11 : 2'b00)));

  a_r6_tlr_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && tap_reset && flag_done && !startup_done) |=> (mode == 2'b11 && !flag_enabled));

  a_r7_oper_entry_io_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |=> (mode != 2'b11 || io_disable));

  a_r8_access_startup: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && ev_disable && !startup_done && !tap_reset) |=> (startup_req && mode == 2'b01));

  a_r9_other_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_other && !ev_enable && !ev_disable && !startup_done && !tap_reset && mode != 2'b10)
      |=> ($stable(mode) && $stable(flag_done) && $stable(io_disable)));

endmodule

bind cfg_isc_mode cfg_isc_mode_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_enable    (ev_enable),
  .ev_disable   (ev_disable),
  .ev_other     (ev_other),
  .tap_reset    (tap_reset),
  .startup_done (startup_done),
  .status_ok    (status_ok),
  .mode         (mode),
  .flag_enabled (flag_enabled),
  .flag_done    (flag_done),
  .shutdown_req (shutdown_req),
  .startup_req  (startup_req),
  .io_disable   (io_disable)
);

// File: tb/tb_cfg_isc_mode.sv
`timescale 1ns/1ps
module tb_cfg_isc_mode;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_enable = 1'b0, ev_disable = 1'b0, ev_other = 1'b0;
  logic       tap_reset = 1'b0, startup_done = 1'b0, status_ok = 1'b0;
  logic [1:0] mode;
  logic       flag_enabled, flag_done, shutdown_req, startup_req, io_disable;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  int m_mode = 0;
  bit m_en = 0, m_done = 0, m_io = 0, m_pend = 0, m_sd = 0, m_su = 0;

  always #5 clk = ~clk;

  cfg_isc_mode dut (
    .clk(clk), .rst_n(rst_n), .ev_enable(ev_enable), .ev_disable(ev_disable),
    .ev_other(ev_other), .tap_reset(tap_reset), .startup_done(startup_done),
    .status_ok(status_ok), .mode(mode), .flag_enabled(flag_enabled),
    .flag_done(flag_done), .shutdown_req(shutdown_req), .startup_req(startup_req),
    .io_disable(io_disable)
  );

  task automatic compare(input string tag);
    logic [6:0] act, exp;
    act = {mode, flag_enabled, flag_done, shutdown_req, startup_req, io_disable};
    exp = {m_mode[1:0], m_en, m_done, m_sd, m_su, !m_io};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {mode,en,done,sd,su,iodis} actual %b expected %b", tag, act, exp);
    end
  endtask

  // model update with the inputs presented this cycle
  task automatic model(input bit en, dis, tlr, sd, ok);
    m_sd = 0; m_su = 0;
    case (m_mode)
      0: if (en) begin m_mode = 1; m_en = 1; end
      1: begin
        if (sd) begin m_mode = 2; m_en = 0; m_done = ok; end
        else if (tlr && m_done) begin m_mode = 3; m_en = 0; end
        else if (dis) m_su = 1;
      end
      2: begin m_mode = m_done ? 3 : 0; end
      default: begin
        if (en) begin m_mode = 1; m_en = 1; m_sd = 1; m_io = 0; m_pend = 0; end
        else if (sd && m_pend) begin m_io = 1; m_pend = 0; end
        else if (dis) begin m_su = 1; m_pend = 1; end
      end
    endcase
  endtask

  task automatic step(input bit en, dis, oth, tlr, sd, ok, input string tag);
    ev_enable = en; ev_disable = dis; ev_other = oth;
    tap_reset = tlr; startup_done = sd; status_ok = ok;
    @(posedge clk);
    model(en, dis, tlr, sd, ok);
    @(negedge clk);
    ev_enable = 0; ev_disable = 0; ev_other = 0; tap_reset = 0; startup_done = 0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit [7:0] lf;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    step(0,0,1,0,0,0, "R9 other in unprogrammed");
    step(0,0,0,1,1,1, "R9 no enable, no move");
    step(1,0,0,0,0,0, "R2 enable from unprogrammed");
    step(0,1,0,0,0,0, "R8 disable in accessed");
    step(0,0,1,0,0,0, "R9 other in accessed");
    step(0,0,0,1,0,0, "R6 tlr with done clear stays");
    step(0,0,0,0,1,0, "R4 startup end bad status");
    step(1,1,1,1,1,1, "R5 settle to unprogrammed, inputs ignored");
    step(1,0,0,0,0,0, "R2 enable again");
    step(0,0,0,1,1,1, "R10 startup end beats tlr");
    step(1,1,1,1,0,0, "R5 settle to operational, inputs ignored");
    step(0,0,0,0,1,0, "R11 startup end without request");
    step(0,0,1,0,0,0, "R9 other in operational");
    step(0,1,0,0,0,0, "R7 startup request in operational");
    step(0,0,0,0,0,0, "R7 idle with pending request");
    step(0,0,0,0,1,0, "R7 startup end activates io");
    step(0,0,1,0,0,0, "R9 other keeps io active");
    step(1,0,0,0,0,0, "R3 enable from operational");
    step(0,0,0,0,0,0, "R3 shutdown pulse ends");
    step(0,0,0,1,0,0, "R6 tlr with done set jumps");
    step(1,0,0,0,0,0, "R3 re-enter accessed");
    step(0,0,0,0,1,1, "R4 startup end good status");
    step(0,0,0,0,0,0, "R5 settle to operational");

    lf = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[0] & lf[3], lf[1], lf[2], lf[4], lf[5] & lf[6], lf[7] | lf[2], "R9 mixed pattern");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule